// File: doc/BRIEF.md
# Rotating-Master Triple Redundancy Selector

This block sits behind three identical copies of a logic function and passes the value of just one of them to its output. That copy is called the master. The other two are peers. On every cycle the block compares the master against both peers. If the master differs from both, the block treats it as broken. In the same cycle it blanks the output and raises a one-cycle fault pulse. At the next clock edge it hands the master role to the next replica in a fixed rotation.

Only one replica is assumed to fail at a time. When the master disagrees with only one peer, the fault lies in a peer, so the master keeps its role. That case, and any other case where the two peers disagree, is recorded in a sticky flag that a synchronous clear input resets. A saturating counter counts master hand-overs since reset. A bench that corrupts one replica can therefore confirm how many switches took place.

Top module: `tmr_master_select`

## Requirements
- R1: After reset, replica 0 is master: `master_sel_o` is 3'b001, `switch_count_o` is 0, and `peer_mismatch_o` is 0.
- R2: When the master equals at least one peer, `out_data_o` equals the master replica's value and `out_valid_o` is 1 in the same cycle.
- R3: A fault is declared only in a cycle where the master differs from both peers. In that cycle `fault_pulse_o` is 1, `out_valid_o` is 0, and `out_data_o` is all zeros.
- R4: `master_sel_o` is one-hot, and bit i marks replica i as master. After a fault cycle the pointer moves 0 to 1, 1 to 2, and 2 to 0 at the next rising edge. Otherwise it holds.
- R5: In the cycle after a fault, the newly selected master's value is forwarded with `out_valid_o` at 1, provided that replica agrees with a peer.
- R6: `fault_pulse_o` is 0 in every cycle without a fault, so each detection gives a pulse of exactly one cycle.
- R7: `peer_mismatch_o` becomes 1 at the edge that ends a cycle in which the two peers differ. It stays 1 until a clock edge with `peer_clr_i` high, which clears it. A clear takes priority over a new mismatch in the same cycle.
- R8: `switch_count_o` rises by one at each fault edge and saturates at 2^CNT_W-1 (255 by default).
- R9: When the master disagrees with exactly one peer, there is no switch and no pulse, and the output keeps forwarding the master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rep0_i | input | W | Replica 0 value |
| rep1_i | input | W | Replica 1 value |
| rep2_i | input | W | Replica 2 value |
| peer_clr_i | input | 1 | Synchronous clear of the sticky peer-mismatch flag |
| out_data_o | output | W | Forwarded master value, zero while blanked |
| out_valid_o | output | 1 | Output holds a trusted master value |
| fault_pulse_o | output | 1 | High in the cycle a master fault is detected |
| peer_mismatch_o | output | 1 | Sticky flag: the two peers have disagreed |
| switch_count_o | output | CNT_W | Saturating count of master hand-overs |
| master_sel_o | output | 3 | One-hot current master pointer |

## Verification
The data output, the valid flag and the fault pulse are combinational in the replica inputs and the pointer, so they are due in the same cycle as the stimulus. The pointer, the switch counter and the sticky flag change only at the following rising edge. The bench changes inputs on the falling edge and checks combinational results 5 ns later. It checks registered results at the sample point of the next applied cycle, which comes after exactly one rising edge. The saturation test keeps a model of which replica is master, corrupts that replica 260 times in a row, and expects the counter to stop at 255.

// File: rtl/tmr_master_select.sv
module tmr_master_select #(
  parameter int W     = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     rep0_i,
  input  logic [W-1:0]     rep1_i,
  input  logic [W-1:0]     rep2_i,
  input  logic             peer_clr_i,
  output logic [W-1:0]     out_data_o,
  output logic             out_valid_o,
  output logic             fault_pulse_o,
  output logic             peer_mismatch_o,
  output logic [CNT_W-1:0] switch_count_o,
  output logic [2:0]       master_sel_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0]   ptr;
  logic [W-1:0] mst, pa, pb;
  logic         fault, peers_differ, sticky;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    unique case (ptr)
      3'b010:  begin mst = rep1_i; pa = rep2_i; pb = rep0_i; end
      3'b100:  begin mst = rep2_i; pa = rep0_i; pb = rep1_i; end
      default: begin mst = rep0_i; pa = rep1_i; pb = rep2_i; end
    endcase
  end

  assign fault        = (mst != pa) && (mst != pb);
  assign peers_differ = (pa != pb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= 3'b001;
    else if (fault) ptr <= {ptr[1:0], ptr[2]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (fault && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            sticky <= 1'b0;
    else if (peer_clr_i)   sticky <= 1'b0;
    else if (peers_differ) sticky <= 1'b1;
  end

  assign out_data_o      = fault ? '0 : mst;
  assign out_valid_o     = ~fault;
  assign fault_pulse_o   = fault;
  assign peer_mismatch_o = sticky;
  assign switch_count_o  = cnt;
  assign master_sel_o    = ptr;

  a_r4_onehot_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(master_sel_o));

  a_r4_rotate_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse_o |=> master_sel_o == {$past(master_sel_o[1:0]), $past(master_sel_o[2])});

  a_r4_hold_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_pulse_o |=> $stable(master_sel_o));

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_pulse_o && switch_count_o != CNT_MAX) |=> switch_count_o == $past(switch_count_o) + 1'b1);

  a_r8_count_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_count_o == CNT_MAX) |=> switch_count_o == CNT_MAX);

  a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_mismatch_o && !peer_clr_i) |=> peer_mismatch_o);

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    peer_clr_i |=> !peer_mismatch_o);

  a_r3_blank_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse_o |-> (!out_valid_o && out_data_o == '0));

endmodule

// File: tb/sim_tmr_master_select.sv
module sim_tmr_master_select;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] r0 = 0, r1 = 0, r2 = 0;
  logic clr = 0;
  logic [W-1:0] dout;
  logic vld, pulse, pm;
  logic [7:0] cnt;
  logic [2:0] sel;

  int checks = 0, fails = 0;
  int m = 0;

  always #10 clk = ~clk;

  tmr_master_select #(.W(W), .CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .rep0_i(r0), .rep1_i(r1), .rep2_i(r2),
    .peer_clr_i(clr), .out_data_o(dout), .out_valid_o(vld),
    .fault_pulse_o(pulse), .peer_mismatch_o(pm), .switch_count_o(cnt),
    .master_sel_o(sel));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, logic cl = 0);
    @(negedge clk);
    r0 = a; r1 = b; r2 = c; clr = cl;
    #5;
  endtask

  function automatic logic [2:0] onehot(int i);
    return 3'b001 << i;
  endfunction

  task automatic t_reset;
    check("R1 sel", sel, 3'b001);
    check("R1 count", cnt, 0);
    check("R1 sticky", pm, 0);
  endtask

  task automatic t_forward;
    logic [W-1:0] pats[4] = '{8'h00, 8'hA5, 8'h3C, 8'hFF};
    foreach (pats[i]) begin
      apply(pats[i], pats[i], pats[i]);
      check("R2 data", dout, pats[i]);
      check("R2 valid", vld, 1);
      check("R6 no pulse", pulse, 0);
    end
    check("R4 hold", sel, 3'b001);
  endtask

  task automatic t_one_peer;
    apply(8'h11, 8'h99, 8'h11);
    check("R9 data", dout, 8'h11);
    check("R9 valid", vld, 1);
    check("R9 no pulse", pulse, 0);
    check("R7 not yet", pm, 0);
    apply(8'h11, 8'h11, 8'h11);
    check("R9 no switch", sel, 3'b001);
    check("R7 sticky set", pm, 1);
    apply(8'h11, 8'h11, 8'h11);
    check("R7 sticky held", pm, 1);
    apply(8'h11, 8'h11, 8'h11, 1);
    apply(8'h11, 8'h11, 8'h11);
    check("R7 cleared", pm, 0);
    apply(8'h11, 8'h22, 8'h11, 1);
    apply(8'h11, 8'h11, 8'h11);
    check("R7 clear wins", pm, 0);
    check("R8 count unchanged", cnt, 0);
  endtask

  task automatic t_switch;
    apply(8'h5A, 8'h42, 8'h42);
    check("R3 pulse", pulse, 1);
    check("R3 valid low", vld, 0);
    check("R3 data zero", dout, 0);
    apply(8'h5A, 8'h42, 8'h42);
    check("R4 to 1", sel, 3'b010);
    check("R5 data", dout, 8'h42);
    check("R5 valid", vld, 1);
    check("R6 one cycle", pulse, 0);
    check("R8 count 1", cnt, 1);
    apply(8'h42, 8'h77, 8'h42);
    check("R3 pulse m1", pulse, 1);
    apply(8'h42, 8'h42, 8'h42);
    check("R4 to 2", sel, 3'b100);
    apply(8'h42, 8'h42, 8'h13);
    check("R3 pulse m2", pulse, 1);
    apply(8'h42, 8'h42, 8'h42);
    check("R4 wrap", sel, 3'b001);
    check("R8 count 3", cnt, 3);
    m = 0;
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 260; k++) begin
      logic [W-1:0] v = 8'h30;
      logic [W-1:0] a = (m == 0) ? ~v : v;
      logic [W-1:0] b = (m == 1) ? ~v : v;
      logic [W-1:0] c = (m == 2) ? ~v : v;
      apply(a, b, c);
      if (pulse !== 1'b1) check("R3 sat pulse", pulse, 1);
      m = (m + 1) % 3;
    end
    apply(8'h30, 8'h30, 8'h30);
    check("R8 saturated", cnt, 255);
    check("R4 model", sel, onehot(m));
    check("R2 after sat", dout, 8'h30);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #5;
    t_reset();
    t_forward();
    t_one_peer();
    t_switch();
    t_saturate();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule